// File: doc/BRIEF.md
# Configurable UART with Baud Generator

A full-duplex asynchronous serial port for on-chip use. A frame is a low start bit, then 5, 6, 7 or 8 data bits with the least significant bit first, then an optional ninth bit, then one or more high stop bits. The ninth bit is either a parity bit or a free extra bit. Parity can be odd, even, forced one or forced zero. The extra bit is passed through unchanged, so software can use it for multiprocessor addressing. The stop can be short (one bit) or long. A long stop is two bits, or one and a half bits when the frame has five data bits.

Timing comes from an internal rate generator. A 16-bit reload value sets an interval of `65536 - reload` counts, and a divider of 1, 4, 12 or 48 sits in front of it. One bit lasts `2 * (65536 - reload) * divider` clock cycles. For example, at 48 MHz with divider 1 and reload 65120, one bit is 832 cycles, which is about 57600 baud. The generator produces sixteen sampling ticks per bit, with fractional accumulation when the interval is not a multiple of eight. The transmitter and the receiver both step on these ticks.

Received words go into a three-entry queue. A word that arrives while the queue is full is dropped. Parity and framing faults are kept in a sticky error flag, and overflow is kept in a sticky overflow flag. Both flags are cleared by a single pulse on `err_clr_i`. The bit rate must stay below the system clock divided by 16.

Top module: `uart_core`

## Requirements
- R1: After reset the line `tx_o` idles high. A frame is one low start bit, then the data bits least significant first, then high stop bits. `len_sel_i` picks the data width: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Data input bits above the chosen width are not sent.
- R2: When `par_en_i` is 1, one parity bit follows the data. `par_mode_i` picks its value: 00 is odd (the data ones plus the parity bit give an odd total), 01 is even, 10 always sends 1 and 11 always sends 0.
- R3: The receiver sets the sticky `rx_err_o` when a parity bit does not match or when the first stop bit is sampled low. The word is still stored in the queue. A one-cycle pulse on `err_clr_i` clears `rx_err_o` and `rx_ovf_o`.
- R4: When `xbit_en_i` is 1 and `par_en_i` is 0, the transmitter sends `tx_xbit_i` as a ninth bit after the data, and the receiver returns that bit on `rx_xbit_o`. When both are 1, parity takes the slot: `tx_xbit_i` is ignored and `rx_xbit_o` reads 0.
- R5: With `long_stop_i` at 0 the stop lasts 16 ticks. With `long_stop_i` at 1 it lasts 32 ticks, or 24 ticks when the width is 5 bits. `tx_busy_o` falls at the end of the stop.
- R6: One bit lasts `2 * (65536 - reload_i) * P` clock cycles. `presc_sel_i` picks P: 00 is 1, 01 is 4, 10 is 12 and 11 is 48.
- R7: The receiver steps on 16 ticks per bit and samples each bit at its middle. A falling edge that is high again at the middle of the start bit is rejected, and no word is stored.
- R8: Received words come out of `rx_data_o` and `rx_xbit_o` in arrival order. `rx_count_o` gives the number of stored words (0 to 3), and `rx_valid_o` is 1 whenever that count is not zero. A pulse on `rx_pop_i` removes the oldest word.
- R9: A word that arrives while three words are stored is dropped, the three stored words are kept, and the sticky `rx_ovf_o` is set.
- R10: A pulse on `tx_start_i` while `tx_busy_o` is 1 is ignored. The frame in progress is not changed and no further frame follows it.
- R11: After reset `tx_busy_o`, `rx_valid_o`, `rx_count_o`, `rx_err_o` and `rx_ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_sel_i | input | 2 | Data width code (5 to 8 bits) |
| par_en_i | input | 1 | Enable the parity bit |
| par_mode_i | input | 2 | Parity kind: odd, even, one, zero |
| xbit_en_i | input | 1 | Enable the free ninth bit |
| long_stop_i | input | 1 | Select the long stop |
| presc_sel_i | input | 2 | Divider code: 1, 4, 12, 48 |
| reload_i | input | TIMER_W | Interval reload value |
| tx_data_i | input | 8 | Word to send |
| tx_xbit_i | input | 1 | Ninth bit to send |
| tx_start_i | input | 1 | Start a frame when idle |
| tx_o | output | 1 | Serial output |
| tx_busy_o | output | 1 | Frame in progress |
| rx_i | input | 1 | Serial input |
| rx_pop_i | input | 1 | Remove the oldest stored word |
| rx_data_o | output | 8 | Oldest stored word |
| rx_xbit_o | output | 1 | Ninth bit of the oldest word |
| rx_valid_o | output | 1 | Queue not empty |
| rx_count_o | output | $clog2(FIFO_DEPTH+1) | Stored word count |
| rx_err_o | output | 1 | Sticky parity or stop error |
| rx_ovf_o | output | 1 | Sticky overflow |
| err_clr_i | input | 1 | Clear both sticky flags |

## Verification
The bench measures how long `tx_busy_o` stays high. This separates the 24-tick stop used for five data bits from the 32-tick stop, and a design that always used two bits would run 8 ticks long. A three-cycle low glitch on `rx_i` must leave the queue empty; a receiver that skipped the mid-start check would store a 0xFF word. A fourth word sent into a full queue must raise the overflow flag and leave the first three words readable in order; a design that overwrote the oldest or the newest entry would return the wrong sequence. The bench also starts a frame with both parity and the extra bit enabled and checks that the ninth bit carries parity; it pulses start in the middle of a frame and checks that no second frame appears. Finally it measures single bit widths at every divider setting and at the 57600-baud reload value.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_ONE   = 2'b10,
    PAR_ZERO  = 2'b11
  } par_mode_e;

  function automatic logic [5:0] presc_div(input logic [1:0] sel);
    case (sel)
      2'b00:   return 6'd1;
      2'b01:   return 6'd4;
      2'b10:   return 6'd12;
      default: return 6'd48;
    endcase
  endfunction

  function automatic logic [3:0] data_len(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic [7:0] len_mask(input logic [1:0] sel);
    return 8'hFF >> (2'd3 - sel);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input par_mode_e m);
    case (m)
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_core_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int OSR     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         presc_sel_i,
  input  logic [TIMER_W-1:0] reload_i,
  output logic               tick_o
);
  localparam int ACC_W = TIMER_W + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(OSR / 2);

  logic [5:0]       pcnt, pdiv;
  logic             ptick;
  logic [ACC_W-1:0] acc, acc_nx, span;

  assign pdiv   = presc_div(presc_sel_i);
  assign ptick  = (pcnt >= pdiv - 6'd1);
  assign span   = (ACC_W'(1) << TIMER_W) - ACC_W'(reload_i);
  assign acc_nx = acc + STEP;
  // fractional accumulation: OSR ticks per 2*span prescaled counts
  assign tick_o = ptick && (acc_nx >= span);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt <= '0;
      acc  <= '0;
    end else begin
      pcnt <= ptick ? 6'd0 : pcnt + 6'd1;
      if (ptick) acc <= tick_o ? acc_nx - span : acc_nx;
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_core_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] len_sel_i,
  input  logic       par_en_i,
  input  logic [1:0] par_mode_i,
  input  logic       xbit_en_i,
  input  logic       long_stop_i,
  input  logic [7:0] data_i,
  input  logic       xbit_i,
  input  logic       start_i,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int SH_W  = 11;
  localparam int REM_W = $clog2(OSR * 12 + 1);
  localparam int SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic [3:0]      dlen;
  logic            ext, extra;
  logic [SH_W-1:0] frame_c, sh;
  logic [REM_W-1:0] stop_c, total_c, rem;
  logic [SUB_W-1:0] sub;
  logic            active;

  assign dlen  = data_len(len_sel_i);
  assign ext   = par_en_i | xbit_en_i;
  assign extra = par_en_i ? par_bit(data_i & len_mask(len_sel_i), par_mode_e'(par_mode_i))
                          : xbit_i;

  always_comb begin
    frame_c    = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < dlen) frame_c[i+1] = data_i[i];
    end
    if (ext) frame_c[dlen + 4'd1] = extra;
  end

  assign stop_c  = !long_stop_i ? REM_W'(OSR)
                 : (dlen == 4'd5) ? REM_W'(OSR * 3 / 2) : REM_W'(2 * OSR);
  assign total_c = REM_W'(OSR) * (REM_W'(dlen) + REM_W'(ext) + REM_W'(1)) + stop_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      active <= 1'b0;
      sh     <= '1;
      rem    <= '0;
      sub    <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        sh     <= frame_c;
        rem    <= total_c;
      end
    end else if (tick_i) begin
      if (!active) begin
        active <= 1'b1;
        sub    <= '0;
      end else if (rem == REM_W'(1)) begin
        active <= 1'b0;
        busy_o <= 1'b0;
      end else begin
        rem <= rem - REM_W'(1);
        sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
        if (sub == SUB_LAST) sh <= {1'b1, sh[SH_W-1:1]};
      end
    end
  end

  assign tx_o = active ? sh[0] : 1'b1;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_core_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] len_sel_i,
  input  logic       par_en_i,
  input  logic [1:0] par_mode_i,
  input  logic       xbit_en_i,
  input  logic       err_clr_i,
  input  logic       rx_i,
  output logic       push_o,
  output logic [7:0] data_o,
  output logic       xbit_o,
  output logic       err_o
);
  localparam int SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  rx_state_e        st;
  logic             s1, s2, prev, xb, bad_par;
  logic [SUB_W-1:0] sub;
  logic [3:0]       idx, dlen, nbits;
  logic [7:0]       sh, data_c;

  assign dlen    = data_len(len_sel_i);
  assign nbits   = dlen + {3'b000, par_en_i | xbit_en_i};
  assign data_c  = sh >> (4'd8 - dlen);
  assign bad_par = par_en_i && (xb != par_bit(data_c, par_mode_e'(par_mode_i)));
  assign push_o  = (st == RX_STOP) && tick_i && (sub == SUB_LAST);
  assign data_o  = data_c;
  assign xbit_o  = xbit_en_i & ~par_en_i & xb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      st <= RX_IDLE; sub <= '0; idx <= '0;
      sh <= '0; xb <= 1'b0; err_o <= 1'b0;
    end else begin
      s1 <= rx_i;
      s2 <= s1;
      if (err_clr_i) err_o <= 1'b0;
      if (push_o && (bad_par || !s2)) err_o <= 1'b1;
      if (tick_i) begin
        prev <= s2;
        unique case (st)
          RX_IDLE: if (prev && !s2) begin
            st  <= RX_START;
            sub <= '0;
          end
          RX_START: if (sub == SUB_MID) begin
            sub <= '0;
            idx <= '0;
            st  <= s2 ? RX_IDLE : RX_BITS;  // reject short glitch
          end else sub <= sub + 1'b1;
          RX_BITS: if (sub == SUB_LAST) begin
            sub <= '0;
            if (idx < dlen) sh <= {s2, sh[7:1]};
            else            xb <= s2;
            idx <= idx + 4'd1;
            if (idx == nbits - 4'd1) st <= RX_STOP;
          end else sub <= sub + 1'b1;
          RX_STOP: if (sub == SUB_LAST) begin
            sub <= '0;
            st  <= RX_IDLE;
          end else sub <= sub + 1'b1;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 3,
  parameter int W     = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [W-1:0]               wdata_i,
  input  logic                       pop_i,
  input  logic                       clr_i,
  output logic [W-1:0]               head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             push_ok, pop_ok;

  assign pop_ok  = pop_i && (count_o != '0);
  assign push_ok = push_i && ((count_o != CNT_W'(DEPTH)) || pop_i);
  assign head_o  = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (push_ok) begin
        mem[wptr] <= wdata_i;
        wptr      <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      end
      if (pop_ok) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      count_o <= count_o + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (clr_i) ovf_o <= 1'b0;
      if (push_i && !push_ok) ovf_o <= 1'b1;  // newest dropped
    end
  end
endmodule

// File: rtl/uart_core.sv
module uart_core #(
  parameter int TIMER_W    = 16,
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      len_sel_i,
  input  logic                            par_en_i,
  input  logic [1:0]                      par_mode_i,
  input  logic                            xbit_en_i,
  input  logic                            long_stop_i,
  input  logic [1:0]                      presc_sel_i,
  input  logic [TIMER_W-1:0]              reload_i,
  input  logic [7:0]                      tx_data_i,
  input  logic                            tx_xbit_i,
  input  logic                            tx_start_i,
  output logic                            tx_o,
  output logic                            tx_busy_o,
  input  logic                            rx_i,
  input  logic                            rx_pop_i,
  output logic [7:0]                      rx_data_o,
  output logic                            rx_xbit_o,
  output logic                            rx_valid_o,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count_o,
  output logic                            rx_err_o,
  output logic                            rx_ovf_o,
  input  logic                            err_clr_i
);
  logic       tick, push, rx_xb;
  logic [7:0] rx_word;

  uart_baud_gen #(.TIMER_W(TIMER_W), .OSR(OSR)) u_baud (
    .clk_i, .rst_ni, .presc_sel_i, .reload_i, .tick_o(tick)
  );

  uart_tx #(.OSR(OSR)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .len_sel_i, .par_en_i, .par_mode_i,
    .xbit_en_i, .long_stop_i, .data_i(tx_data_i), .xbit_i(tx_xbit_i),
    .start_i(tx_start_i), .tx_o, .busy_o(tx_busy_o)
  );

  uart_rx #(.OSR(OSR)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .len_sel_i, .par_en_i, .par_mode_i,
    .xbit_en_i, .err_clr_i, .rx_i, .push_o(push), .data_o(rx_word),
    .xbit_o(rx_xb), .err_o(rx_err_o)
  );

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i({rx_xb, rx_word}),
    .pop_i(rx_pop_i), .clr_i(err_clr_i), .head_o({rx_xbit_o, rx_data_o}),
    .count_o(rx_count_o), .ovf_o(rx_ovf_o)
  );

  assign rx_valid_o = (rx_count_o != '0);
endmodule

// File: rtl/uart_core_chk.sv
module uart_core_chk #(
  parameter int FIFO_DEPTH = 3
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            tx_start_i,
  input logic                            tx_o,
  input logic                            tx_busy_o,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_count_o,
  input logic                            rx_err_o,
  input logic                            rx_ovf_o,
  input logic                            err_clr_i
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  // R1
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> tx_o);

  // R10
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |-> $past(tx_start_i));

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_o <= CNT_W'(FIFO_DEPTH));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ovf_o && !err_clr_i |=> rx_ovf_o);

  // R9
  ovf_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> $past(rx_count_o) == CNT_W'(FIFO_DEPTH));

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o && !err_clr_i |=> rx_err_o);
endmodule

bind uart_core uart_core_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_start_i(tx_start_i), .tx_o(tx_o),
  .tx_busy_o(tx_busy_o), .rx_count_o(rx_count_o), .rx_err_o(rx_err_o),
  .rx_ovf_o(rx_ovf_o), .err_clr_i(err_clr_i)
);

// File: tb/tb_uart_core.sv
`timescale 1ns/1ps
module tb_uart_core;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] len_sel, par_mode, presc_sel;
  logic par_en, xbit_en, long_stop, tx_xbit, tx_start, rx_line, rx_pop, err_clr;
  logic [15:0] reload;
  logic [7:0] tx_data, rx_data;
  logic tx_line, tx_busy, rx_xbit, rx_valid, rx_err, rx_ovf;
  logic [1:0] rx_count;

  int checks = 0, errors = 0, bitcyc = 16;
  bit done = 0;

  always #10 clk = ~clk;

  uart_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .len_sel_i(len_sel), .par_en_i(par_en),
    .par_mode_i(par_mode), .xbit_en_i(xbit_en), .long_stop_i(long_stop),
    .presc_sel_i(presc_sel), .reload_i(reload), .tx_data_i(tx_data),
    .tx_xbit_i(tx_xbit), .tx_start_i(tx_start), .tx_o(tx_line),
    .tx_busy_o(tx_busy), .rx_i(rx_line), .rx_pop_i(rx_pop), .rx_data_o(rx_data),
    .rx_xbit_o(rx_xbit), .rx_valid_o(rx_valid), .rx_count_o(rx_count),
    .rx_err_o(rx_err), .rx_ovf_o(rx_ovf), .err_clr_i(err_clr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input string what, input int act, input int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic bpar(input logic [7:0] d, input int dl, input int mode);
    logic [7:0] m = d & (8'hFF >> (8 - dl));
    case (mode)
      0: return ~^m;
      1: return ^m;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] mk_frame(input logic [7:0] d, input int dl,
                                           input bit hx, input bit xv);
    logic [15:0] f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dl; i++) f[i+1] = d[i];
    if (hx) f[dl+1] = xv;
    return f;
  endfunction

  task automatic set_cfg(input int len, input bit pe, input int pm, input bit xe,
                         input bit ls, input int ps, input int rl, input int bc);
    @(negedge clk);
    len_sel = 2'(len - 5); par_en = pe; par_mode = 2'(pm); xbit_en = xe;
    long_stop = ls; presc_sel = 2'(ps); reload = 16'(rl); bitcyc = bc;
  endtask

  task automatic tx_send(input logic [7:0] d, input bit xb);
    @(negedge clk);
    tx_data = d; tx_xbit = xb; tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic tx_capture(input int nb, output logic [15:0] bits);
    bits = '1;
    while (tx_line) @(negedge clk);
    repeat (bitcyc / 2) @(negedge clk);
    bits[0] = tx_line;
    for (int i = 1; i < nb; i++) begin
      repeat (bitcyc) @(negedge clk);
      bits[i] = tx_line;
    end
  endtask

  task automatic wait_idle();
    while (tx_busy) @(negedge clk);
  endtask

  task automatic tx_frame_chk(input string req, input logic [7:0] d, input bit xb,
                              input int dl, input bit hx, input bit xv);
    logic [15:0] got, exp;
    int nb = dl + (hx ? 1 : 0) + 2;
    tx_send(d, xb);
    tx_capture(nb, got);
    exp = mk_frame(d, dl, hx, xv);
    chk(req, "tx frame bits", int'(got & 16'((1 << nb) - 1)), int'(exp & 16'((1 << nb) - 1)));
    wait_idle();
  endtask

  task automatic rx_drive(input logic [7:0] d, input int dl, input bit hx,
                          input bit xv, input bit sv);
    rx_line = 1'b0; repeat (bitcyc) @(negedge clk);
    for (int i = 0; i < dl; i++) begin
      rx_line = d[i]; repeat (bitcyc) @(negedge clk);
    end
    if (hx) begin rx_line = xv; repeat (bitcyc) @(negedge clk); end
    rx_line = sv; repeat (bitcyc) @(negedge clk);
    rx_line = 1'b1; repeat (bitcyc) @(negedge clk);
  endtask

  task automatic rx_read(input string req, input logic [7:0] d, input bit xb);
    @(negedge clk);
    chk(req, "rx_valid_o", int'(rx_valid), 1);
    chk(req, "rx_data_o", int'(rx_data), int'(d));
    chk(req, "rx_xbit_o", int'(rx_xbit), int'(xb));
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // R11
  task automatic t_reset();
    @(negedge clk);
    chk("R11", "tx_o idle", int'(tx_line), 1);
    chk("R11", "tx_busy_o", int'(tx_busy), 0);
    chk("R11", "rx_valid_o", int'(rx_valid), 0);
    chk("R11", "rx_count_o", int'(rx_count), 0);
    chk("R11", "rx_err_o", int'(rx_err), 0);
    chk("R11", "rx_ovf_o", int'(rx_ovf), 0);
  endtask

  // R1
  task automatic t_tx_frames();
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    tx_frame_chk("R1", 8'hA5, 1'b0, 8, 0, 0);
    set_cfg(5, 0, 0, 0, 0, 0, 65528, 16);
    tx_frame_chk("R1", 8'hF3, 1'b0, 5, 0, 0);  // upper bits dropped
  endtask

  // R2
  task automatic t_tx_parity();
    for (int m = 0; m < 4; m++) begin
      set_cfg(7, 1, m, 0, 0, 0, 65528, 16);
      tx_frame_chk("R2", 8'h5B, 1'b0, 7, 1, bpar(8'h5B, 7, m));
    end
  endtask

  // R4
  task automatic t_tx_xbit();
    set_cfg(8, 0, 0, 1, 0, 0, 65528, 16);
    tx_frame_chk("R4", 8'h3C, 1'b1, 8, 1, 1'b1);
    tx_frame_chk("R4", 8'h3C, 1'b0, 8, 1, 1'b0);
    set_cfg(8, 1, 1, 1, 0, 0, 65528, 16);
    tx_frame_chk("R4", 8'h03, 1'b1, 8, 1, bpar(8'h03, 8, 1));  // parity wins
  endtask

  task automatic busy_len(input string req, input int len, input bit ls, input int exp);
    int cyc = 0;
    set_cfg(len, 0, 0, 0, ls, 0, 65528, 16);
    tx_send(8'h00, 1'b0);
    while (tx_line) @(negedge clk);
    while (tx_busy) begin @(negedge clk); cyc++; end
    chk_near(req, "frame length in cycles", cyc, exp);
  endtask

  // R5: one tick per cycle here
  task automatic t_stop_len();
    busy_len("R5", 5, 1, 16 * 6 + 24);
    busy_len("R5", 6, 1, 16 * 7 + 32);
    busy_len("R5", 8, 1, 16 * 9 + 32);
    busy_len("R5", 8, 0, 16 * 9 + 16);
    busy_len("R5", 5, 0, 16 * 6 + 16);
  endtask

  task automatic bit_width(input int ps, input int rl, input int exp);
    int cyc = 0;
    set_cfg(8, 0, 0, 0, 0, ps, rl, exp);
    tx_send(8'h01, 1'b0);
    while (tx_line) @(negedge clk);
    while (!tx_line) begin @(negedge clk); cyc++; end
    chk_near("R6", "start bit width", cyc, exp);
    wait_idle();
  endtask

  // R6
  task automatic t_baud();
    bit_width(2, 65528, 2 * 8 * 12);
    bit_width(3, 65528, 2 * 8 * 48);
    bit_width(0, 65120, 2 * 416);
    bit_width(1, 65526, 2 * 10 * 4);
    set_cfg(8, 0, 0, 0, 0, 1, 65526, 80);
    tx_frame_chk("R6", 8'h3C, 1'b0, 8, 0, 0);
  endtask

  // R7 R8
  task automatic t_rx_basic();
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    rx_drive(8'h96, 8, 0, 0, 1);
    rx_drive(8'h41, 8, 0, 0, 1);
    @(negedge clk);
    chk("R8", "rx_count_o after two", int'(rx_count), 2);
    rx_read("R8", 8'h96, 1'b0);
    rx_read("R8", 8'h41, 1'b0);
    set_cfg(6, 0, 0, 1, 0, 0, 65528, 16);
    rx_drive(8'h2A, 6, 1, 1, 1);
    rx_read("R4", 8'h2A, 1'b1);
    set_cfg(8, 0, 0, 0, 0, 1, 65526, 80);
    rx_drive(8'hC3, 8, 0, 0, 1);
    rx_read("R7", 8'hC3, 1'b0);
  endtask

  // R7
  task automatic t_rx_glitch();
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    rx_line = 1'b0; repeat (3) @(negedge clk);
    rx_line = 1'b1; repeat (60) @(negedge clk);
    chk("R7", "count after glitch", int'(rx_count), 0);
    chk("R7", "err after glitch", int'(rx_err), 0);
    rx_drive(8'h5A, 8, 0, 0, 1);
    rx_read("R7", 8'h5A, 1'b0);
  endtask

  // R3
  task automatic t_rx_err();
    set_cfg(8, 1, 1, 0, 0, 0, 65528, 16);
    rx_drive(8'h07, 8, 1, 1'b1, 1);
    @(negedge clk);
    chk("R3", "err on good parity", int'(rx_err), 0);
    rx_read("R3", 8'h07, 1'b0);
    rx_drive(8'h07, 8, 1, 1'b0, 1);
    @(negedge clk);
    chk("R3", "err on bad parity", int'(rx_err), 1);
    rx_read("R3", 8'h07, 1'b0);
    clear_flags();
    chk("R3", "err after clear", int'(rx_err), 0);
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    rx_drive(8'h55, 8, 0, 0, 0);
    @(negedge clk);
    chk("R3", "err on low stop", int'(rx_err), 1);
    chk("R3", "count after low stop", int'(rx_count), 1);
    rx_read("R3", 8'h55, 1'b0);
    clear_flags();
  endtask

  // R8 R9
  task automatic t_fifo_ovf();
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    rx_drive(8'h11, 8, 0, 0, 1);
    rx_drive(8'h22, 8, 0, 0, 1);
    rx_drive(8'h33, 8, 0, 0, 1);
    @(negedge clk);
    chk("R8", "count when full", int'(rx_count), 3);
    chk("R9", "ovf before fourth", int'(rx_ovf), 0);
    rx_drive(8'h44, 8, 0, 0, 1);
    @(negedge clk);
    chk("R9", "ovf after fourth", int'(rx_ovf), 1);
    chk("R9", "count after fourth", int'(rx_count), 3);
    rx_read("R9", 8'h11, 1'b0);
    rx_read("R9", 8'h22, 1'b0);
    rx_read("R9", 8'h33, 1'b0);
    @(negedge clk);
    chk("R9", "empty after reads", int'(rx_valid), 0);
    clear_flags();
    chk("R3", "ovf after clear", int'(rx_ovf), 0);
  endtask

  // R10
  task automatic t_tx_busy_ignore();
    logic [15:0] got;
    int lows = 0;
    set_cfg(8, 0, 0, 0, 0, 0, 65528, 16);
    tx_send(8'h55, 1'b0);
    fork
      tx_capture(10, got);
      begin
        repeat (40) @(negedge clk);
        tx_data = 8'hAA; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
      end
    join
    chk("R10", "frame unchanged", int'(got & 16'h3FF), int'(mk_frame(8'h55, 8, 0, 0) & 16'h3FF));
    wait_idle();
    repeat (200) begin @(negedge clk); if (!tx_line) lows++; end
    chk("R10", "low samples after frame", lows, 0);
    chk("R10", "busy after frame", int'(tx_busy), 0);
  endtask

  initial begin
    len_sel = 2'b11; par_en = 0; par_mode = 0; xbit_en = 0; long_stop = 0;
    presc_sel = 0; reload = 16'd65528; tx_data = 0; tx_xbit = 0; tx_start = 0;
    rx_line = 1'b1; rx_pop = 0; err_clr = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_tx_frames();
    t_tx_parity();
    t_tx_xbit();
    t_stop_len();
    t_baud();
    t_rx_basic();
    t_rx_glitch();
    t_rx_err();
    t_fifo_ovf();
    t_tx_busy_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule